// File: doc/BRIEF.md
# Segmented Bus Segment Switch

This block sits at each point where a component attaches to a segmented data bus. It has three ports: the segment to its left, the segment to its right, and the local component. Each port is modelled as a separate data input, a data output and an output enable, so the block needs no internal tri-states. A neighbouring segment or the component sees the switch as a driver that only comes on when its enable is high.

A compact 4-bit route code picks one of the paths. Data can pass from one segment to the other in either direction, from the component onto one or both segments, or from either segment into the component. A small decoder inside the switch expands the code into per-port enables and source selects. Outputs that are not part of the chosen path stay undriven. The route code is captured on the rising clock edge. The selected path is then a purely combinational connection that carries data in the same cycle. There is no handshake and no back-pressure, because conflicts are assumed to have been removed by a schedule fixed at design time. For the same reason the data pins carry no valid/ready pair.

Top module: `segbus_switch`

## Requirements
- R1: While reset (rst_n low) is applied, all three output enables are 0 and all three data outputs are 0, whatever the data inputs carry.
- R2: `ctrl_code` is captured on the rising edge of `clk`. The outputs follow the code captured at the most recent edge and do not change when `ctrl_code` changes between edges.
- R3: Code 4'b0001 (left to right) drives only the right port: `right_oe`=1, `left_oe`=0, `comp_oe`=0, and `right_dout` equals `left_din`.
- R4: Code 4'b0010 (right to left) drives only the left port, and `left_dout` equals `right_din`.
- R5: Code 4'b0011 drives only the left port from `comp_din`. Code 4'b0100 drives only the right port from `comp_din`.
- R6: Code 4'b0101 (multicast) drives both the left and the right port from `comp_din`, and `comp_oe` stays 0.
- R7: Code 4'b0110 drives only the component port from `left_din`. Code 4'b0111 drives only the component port from `right_din`.
- R8: Code 4'b1100 isolates the switch so that no enable is set. Every code not listed in R3 to R7 behaves the same way.
- R9: A data output whose enable is 0 reads as all zeros.
- R10: While a path is configured, a change on its source data input appears on the sink data output in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the route code is captured on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset to the isolated state |
| ctrl_code | input | 4 | Route code |
| left_din | input | DATA_W | Value present on the left segment |
| left_dout | output | DATA_W | Value the switch puts on the left segment |
| left_oe | output | 1 | Left segment drive enable |
| right_din | input | DATA_W | Value present on the right segment |
| right_dout | output | DATA_W | Value the switch puts on the right segment |
| right_oe | output | 1 | Right segment drive enable |
| comp_din | input | DATA_W | Data offered by the local component |
| comp_dout | output | DATA_W | Data delivered to the local component |
| comp_oe | output | 1 | Component port drive enable |

## Verification
A new route code takes effect at the first rising edge after it is applied. The enables and routed data are then valid for the rest of that cycle, because data passes through no register. The scoreboard driver applies a code and its data on a falling edge. The monitor compares every port a quarter period after the following rising edge. Two direct checks look between edges: one confirms that a code change has no effect before the edge, and one confirms that a change on a source input reaches its sink with no edge at all.

// File: rtl/segsw_pkg.sv
package segsw_pkg;

  localparam int NPORT  = 3;
  localparam int CODE_W = 4;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    PORT_L = 2'd0,
    PORT_R = 2'd1,
    PORT_C = 2'd2
  } port_e;

  typedef enum logic [CODE_W-1:0] {
    CODE_L2R  = 4'b0001,
    CODE_R2L  = 4'b0010,
    CODE_C2L  = 4'b0011,
    CODE_C2R  = 4'b0100,
    CODE_C2B  = 4'b0101,
    CODE_L2C  = 4'b0110,
    CODE_R2C  = 4'b0111,
    CODE_IDLE = 4'b1100
  } code_e;

  typedef struct packed {
    logic [NPORT-1:0]            oe;
    logic [NPORT-1:0][SEL_W-1:0] src;
  } route_t;

  function automatic logic code_is_route(input logic [CODE_W-1:0] c);
    return (c == CODE_L2R) || (c == CODE_R2L) || (c == CODE_C2L) ||
           (c == CODE_C2R) || (c == CODE_C2B) || (c == CODE_L2C) ||
           (c == CODE_R2C);
  endfunction

endpackage

// File: rtl/segsw_code_reg.sv
module segsw_code_reg
  import segsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= CODE_IDLE;
    else        code_q <= code_in;
  end

endmodule

// File: rtl/segsw_decoder.sv
module segsw_decoder
  import segsw_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output route_t            route
);

  always_comb begin
    route.oe  = '0;
    route.src = '0;
    case (code)
      CODE_L2R: begin route.oe[PORT_R] = 1'b1; route.src[PORT_R] = PORT_L; end
      CODE_R2L: begin route.oe[PORT_L] = 1'b1; route.src[PORT_L] = PORT_R; end
      CODE_C2L: begin route.oe[PORT_L] = 1'b1; route.src[PORT_L] = PORT_C; end
      CODE_C2R: begin route.oe[PORT_R] = 1'b1; route.src[PORT_R] = PORT_C; end
      CODE_C2B: begin
        route.oe[PORT_L]  = 1'b1; route.src[PORT_L] = PORT_C;
        route.oe[PORT_R]  = 1'b1; route.src[PORT_R] = PORT_C;
      end
      CODE_L2C: begin route.oe[PORT_C] = 1'b1; route.src[PORT_C] = PORT_L; end
      CODE_R2C: begin route.oe[PORT_C] = 1'b1; route.src[PORT_C] = PORT_R; end
      default:  begin route.oe = '0; route.src = '0; end
    endcase
  end

  // R6: at most two outputs, and only under the multicast code
  always_comb begin
    p_fanout_r6: assert ($countones(route.oe) <= 2 &&
                         ($countones(route.oe) < 2 || code == CODE_C2B));
  end

endmodule

// File: rtl/segsw_port_drv.sv
module segsw_port_drv
  import segsw_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PORT_ID = 0
) (
  input  logic                    oe,
  input  logic [SEL_W-1:0]        src,
  input  logic [NPORT*DATA_W-1:0] din_all,
  output logic [DATA_W-1:0]       dout
);

  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (src == SEL_W'(p)) pick = din_all[p*DATA_W +: DATA_W];
    end
    dout = oe ? pick : '0;
  end

  // a port never feeds its own output
  always_comb begin
    p_no_loop_r8: assert (!(oe && src == SEL_W'(PORT_ID)));
  end

endmodule

// File: rtl/segbus_switch.sv
module segbus_switch
  import segsw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        ctrl_code,
  input  logic [DATA_W-1:0] left_din,
  output logic [DATA_W-1:0] left_dout,
  output logic              left_oe,
  input  logic [DATA_W-1:0] right_din,
  output logic [DATA_W-1:0] right_dout,
  output logic              right_oe,
  input  logic [DATA_W-1:0] comp_din,
  output logic [DATA_W-1:0] comp_dout,
  output logic              comp_oe
);

  localparam int BUS_W = NPORT * DATA_W;

  logic [CODE_W-1:0]             code_q;
  route_t                        route;
  logic [BUS_W-1:0]              din_all;
  logic [NPORT-1:0][DATA_W-1:0]  dout_v;

  segsw_code_reg u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_in (ctrl_code),
    .code_q  (code_q)
  );

  segsw_decoder u_dec (
    .code  (code_q),
    .route (route)
  );

  assign din_all = {comp_din, right_din, left_din};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    segsw_port_drv #(.DATA_W(DATA_W), .PORT_ID(g)) u_drv (
      .oe      (route.oe[g]),
      .src     (route.src[g]),
      .din_all (din_all),
      .dout    (dout_v[g])
    );
  end

  assign left_dout  = dout_v[PORT_L];
  assign right_dout = dout_v[PORT_R];
  assign comp_dout  = dout_v[PORT_C];
  assign left_oe    = route.oe[PORT_L];
  assign right_oe   = route.oe[PORT_R];
  assign comp_oe    = route.oe[PORT_C];

  p_ltor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl_code) == CODE_L2R) |->
      ({comp_oe, right_oe, left_oe} == 3'b010 && right_dout == left_din));

  p_rtol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl_code) == CODE_R2L) |->
      ({comp_oe, right_oe, left_oe} == 3'b001 && left_dout == right_din));

  p_comp_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl_code) == CODE_C2R) |->
      ({comp_oe, right_oe, left_oe} == 3'b010 && right_dout == comp_din));

  p_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl_code) == CODE_C2B) |->
      ({comp_oe, right_oe, left_oe} == 3'b011 &&
       left_dout == comp_din && right_dout == comp_din));

  p_to_comp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl_code) == CODE_L2C) |->
      ({comp_oe, right_oe, left_oe} == 3'b100 && comp_dout == left_din));

  p_isolate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !code_is_route($past(ctrl_code))) |->
      {comp_oe, right_oe, left_oe} == 3'b000);

  p_quiet_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_oe |-> left_dout == '0) and (!right_oe |-> right_dout == '0) and
    (!comp_oe |-> comp_dout == '0));

endmodule

// File: tb/sim_segbus_switch.sv
module sim_segbus_switch;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   ctrl_code = 4'b0000;
  logic [W-1:0] left_din = '0, right_din = '0, comp_din = '0;
  logic [W-1:0] left_dout, right_dout, comp_dout;
  logic         left_oe, right_oe, comp_oe;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0]   oe;   // {comp, right, left}
    logic [W-1:0] dl, dr, dc;
    string        tag;
  } exp_t;

  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  segbus_switch #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_code(ctrl_code),
    .left_din(left_din), .left_dout(left_dout), .left_oe(left_oe),
    .right_din(right_din), .right_dout(right_dout), .right_oe(right_oe),
    .comp_din(comp_din), .comp_dout(comp_dout), .comp_oe(comp_oe)
  );

  function automatic exp_t model(input logic [3:0] c, input logic [W-1:0] l,
                                 input logic [W-1:0] r, input logic [W-1:0] k,
                                 input string tag);
    exp_t e;
    e.oe = 3'b000; e.dl = '0; e.dr = '0; e.dc = '0; e.tag = tag;
    case (c)
      4'b0001: begin e.oe = 3'b010; e.dr = l; end
      4'b0010: begin e.oe = 3'b001; e.dl = r; end
      4'b0011: begin e.oe = 3'b001; e.dl = k; end
      4'b0100: begin e.oe = 3'b010; e.dr = k; end
      4'b0101: begin e.oe = 3'b011; e.dl = k; e.dr = k; end
      4'b0110: begin e.oe = 3'b100; e.dc = l; end
      4'b0111: begin e.oe = 3'b100; e.dc = r; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic check_now(input exp_t e);
    checks++;
    if ({comp_oe, right_oe, left_oe} !== e.oe || left_dout !== e.dl ||
        right_dout !== e.dr || comp_dout !== e.dc) begin
      errors++;
      $display("FAIL %s (R9 for off ports): oe=%b dl=%h dr=%h dc=%h expected oe=%b dl=%h dr=%h dc=%h",
               e.tag, {comp_oe, right_oe, left_oe}, left_dout, right_dout, comp_dout,
               e.oe, e.dl, e.dr, e.dc);
    end
  endtask

  // driver: apply on a falling edge, push the expectation
  task automatic step(input logic [3:0] c, input logic [W-1:0] l,
                      input logic [W-1:0] r, input logic [W-1:0] k, input string tag);
    @(negedge clk);
    ctrl_code = c; left_din = l; right_din = r; comp_din = k;
    sbq.push_back(model(c, l, r, k, tag));
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sbq.size() > 0) check_now(sbq.pop_front());
    end
  end

  task automatic drain();
    while (sbq.size() > 0) @(posedge clk);
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    exp_t e;
    // R1: reset holds everything quiet even with a route code and live data
    ctrl_code = 4'b0101; left_din = 8'hA5; right_din = 8'h3C; comp_din = 8'hF0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_now(model(4'b1100, '0, '0, '0, "R1 reset idle"));
    @(negedge clk);
    rst_n = 1'b1;

    step(4'b0001, 8'h11, 8'h22, 8'h33, "R3 left to right");
    step(4'b0001, 8'hFF, 8'h00, 8'h5A, "R3 left to right all ones");
    step(4'b0010, 8'h44, 8'h55, 8'h66, "R4 right to left");
    step(4'b0011, 8'h12, 8'h34, 8'h56, "R5 comp to left");
    step(4'b0100, 8'h9A, 8'hBC, 8'hDE, "R5 comp to right");
    step(4'b0101, 8'h01, 8'h02, 8'hC3, "R6 comp to both");
    step(4'b0110, 8'h7E, 8'h81, 8'h00, "R7 left to comp");
    step(4'b0111, 8'h7E, 8'h81, 8'h00, "R7 right to comp");
    step(4'b1100, 8'hAA, 8'hBB, 8'hCC, "R8 idle code");
    step(4'b0000, 8'hAA, 8'hBB, 8'hCC, "R8 undefined 0000");
    step(4'b1111, 8'hAA, 8'hBB, 8'hCC, "R8 undefined 1111");
    step(4'b1000, 8'hAA, 8'hBB, 8'hCC, "R8 undefined 1000");
    step(4'b0101, 8'h00, 8'h00, 8'h80, "R6 comp to both second pattern");
    step(4'b0010, 8'h00, 8'hFF, 8'h00, "R4 right to left all ones");
    step(4'b1100, 8'h00, 8'h00, 8'h00, "R8 back to idle");
    drain();

    // R2: a code change between edges has no effect until the edge
    @(negedge clk);
    ctrl_code = 4'b0001; left_din = 8'h6D; right_din = 8'h00; comp_din = 8'h00;
    #(CLK_PERIOD/8);
    check_now(model(4'b1100, 8'h6D, 8'h00, 8'h00, "R2 before edge"));
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_now(model(4'b0001, 8'h6D, 8'h00, 8'h00, "R2 after edge"));

    // R10: data follows its source with no clock edge
    #1;
    left_din = 8'h93;
    #1;
    e = model(4'b0001, 8'h93, 8'h00, 8'h00, "R10 same-cycle pass");
    check_now(e);

    @(negedge clk);
    ctrl_code = 4'b1100;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_now(model(4'b1100, 8'h93, 8'h00, 8'h00, "R8 final isolate"));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule